// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits next to a 32K-word shared memory with two independent access ports, called left and right. It watches each port's synchronous access strobe, address, read/write control, output enable and active-low write-inhibit input. It raises an active-low interrupt to one port when the opposite port writes that port's mailbox word.

The left port's mailbox is the second-highest address, 0x7FFE. The right port's mailbox is the highest address, 0x7FFF. A port clears its own interrupt by reading its own mailbox. The memory array stores the mailbox data like any other word; this block never looks at the data.

Both flags come straight from flip-flops. Each flag changes on the clock edge that samples the qualifying access, and is visible in the following cycle. When set and clear land in the same cycle, set wins, so a new message is never lost. A system that does not use the flags can treat the two addresses as ordinary storage and leave both outputs unconnected.

Top module: `dpmb_irq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both lft_irq_n and rgt_irq_n are 1. An assertion of reset while a flag is low returns it to 1.
- R2: A right-port cycle with rgt_acc=1, rgt_wr=1, rgt_busy_n=1 and rgt_addr=0x7FFE (all ones minus one) drives lft_irq_n to 0 in the next cycle.
- R3: A left-port cycle with lft_acc=1, lft_wr=1, lft_busy_n=1 and lft_addr=0x7FFF (all ones) drives rgt_irq_n to 0 in the next cycle.
- R4: A left-port cycle with lft_acc=1, lft_oe=1 and lft_addr=0x7FFE drives lft_irq_n to 1 in the next cycle. lft_wr may be 0 or 1.
- R5: A right-port cycle with rgt_acc=1, rgt_oe=1 and rgt_addr=0x7FFF drives rgt_irq_n to 1 in the next cycle. rgt_wr may be 0 or 1.
- R6: A mailbox write whose writing port has its busy_n input at 0 leaves the target flag unchanged.
- R7: A mailbox access by the owning port clears nothing when either the access strobe or the output enable is 0.
- R8: If the set of a flag and its clear fall in the same cycle, the flag is 0 in the next cycle.
- R9: Writes to any other address leave both flags unchanged. So do a port writing its own mailbox with oe=0 and a port reading the other port's mailbox.
- R10: With no qualifying access, each flag holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_acc | input | 1 | Left port access strobe for this cycle |
| lft_wr | input | 1 | Left port direction, 1 = write |
| lft_oe | input | 1 | Left port output enable |
| lft_busy_n | input | 1 | Left port write permitted when 1 |
| lft_addr | input | 15 | Left port word address |
| rgt_acc | input | 1 | Right port access strobe for this cycle |
| rgt_wr | input | 1 | Right port direction, 1 = write |
| rgt_oe | input | 1 | Right port output enable |
| rgt_busy_n | input | 1 | Right port write permitted when 1 |
| rgt_addr | input | 15 | Right port word address |
| lft_irq_n | output | 1 | Interrupt to the left port, active low |
| rgt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
The bench aims at the cases a plausible mistake would get wrong, and checks every cycle against a reference model.

- A clear that also demanded the read/write control be low would miss the clearing cycle that has the write bit set.
- Swapped mailbox addresses would raise the wrong port's flag.
- A clear given priority over a set would drop a message that arrives in the same cycle the owner reads.
- A set that ignored the write-inhibit input would raise a flag while busy is low.
- A decode that did not require both strobe and output enable would clear on bare address matches.

The bench also covers two timing cases:

- The cycle in which both flags are set at once and cleared at once.
- A reset applied while both flags are low.

// File: rtl/dpmb_irq.sv
module dpmb_irq #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lft_acc,
  input  logic              lft_wr,
  input  logic              lft_oe,
  input  logic              lft_busy_n,
  input  logic [ADDR_W-1:0] lft_addr,
  input  logic              rgt_acc,
  input  logic              rgt_wr,
  input  logic              rgt_oe,
  input  logic              rgt_busy_n,
  input  logic [ADDR_W-1:0] rgt_addr,
  output logic              lft_irq_n,
  output logic              rgt_irq_n
);

  localparam logic [ADDR_W-1:0] RGT_BOX = '1;
  localparam logic [ADDR_W-1:0] LFT_BOX = RGT_BOX - ADDR_W'(1);

  logic set_lft, clr_lft, set_rgt, clr_rgt;
  logic lft_pend, rgt_pend;

  assign set_lft = rgt_acc & rgt_wr & rgt_busy_n & (rgt_addr == LFT_BOX);
  assign clr_lft = lft_acc & lft_oe & (lft_addr == LFT_BOX);
  assign set_rgt = lft_acc & lft_wr & lft_busy_n & (lft_addr == RGT_BOX);
  assign clr_rgt = rgt_acc & rgt_oe & (rgt_addr == RGT_BOX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lft_pend <= 1'b0;
      rgt_pend <= 1'b0;
    end else begin
      lft_pend <= set_lft | (lft_pend & ~clr_lft);
      rgt_pend <= set_rgt | (rgt_pend & ~clr_rgt);
    end
  end

  assign lft_irq_n = ~lft_pend;
  assign rgt_irq_n = ~rgt_pend;

  assert_set_lft_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_lft |=> !lft_irq_n);
  assert_set_rgt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_rgt |=> !rgt_irq_n);
  assert_clr_lft_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_lft && !set_lft) |=> lft_irq_n);
  assert_clr_rgt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rgt && !set_rgt) |=> rgt_irq_n);
  assert_inhibit_lft_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rgt_busy_n && lft_irq_n) |=> lft_irq_n);
  assert_inhibit_rgt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lft_busy_n && rgt_irq_n) |=> rgt_irq_n);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lft && clr_lft) |=> !lft_irq_n);
  assert_hold_lft_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_lft && !clr_lft) |=> $stable(lft_irq_n));
  assert_hold_rgt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_rgt && !clr_rgt) |=> $stable(rgt_irq_n));

endmodule

// File: tb/dpmb_irq_tb.sv
module dpmb_irq_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 15;
  localparam logic [AW-1:0] BOX_L = 15'h7FFE;
  localparam logic [AW-1:0] BOX_R = 15'h7FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lft_acc = 0, lft_wr = 0, lft_oe = 0, lft_busy_n = 1;
  logic rgt_acc = 0, rgt_wr = 0, rgt_oe = 0, rgt_busy_n = 1;
  logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
  logic lft_irq_n, rgt_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic exp_l_n = 1'b1, exp_r_n = 1'b1;
  logic [1:0] q_exp[$];
  string q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  dpmb_irq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lft_acc(lft_acc), .lft_wr(lft_wr), .lft_oe(lft_oe),
    .lft_busy_n(lft_busy_n), .lft_addr(lft_addr),
    .rgt_acc(rgt_acc), .rgt_wr(rgt_wr), .rgt_oe(rgt_oe),
    .rgt_busy_n(rgt_busy_n), .rgt_addr(rgt_addr),
    .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {lft_irq_n,rgt_irq_n} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic cyc(input string tag,
                     input logic la, input logic lw, input logic lo, input logic lb,
                     input logic [AW-1:0] lad,
                     input logic ra, input logic rw, input logic ro, input logic rb,
                     input logic [AW-1:0] rad);
    logic sl, cl, sr, cr;
    @(negedge clk);
    lft_acc = la; lft_wr = lw; lft_oe = lo; lft_busy_n = lb; lft_addr = lad;
    rgt_acc = ra; rgt_wr = rw; rgt_oe = ro; rgt_busy_n = rb; rgt_addr = rad;
    sl = ra & rw & rb & (rad == BOX_L);
    cl = la & lo & (lad == BOX_L);
    sr = la & lw & lb & (lad == BOX_R);
    cr = ra & ro & (rad == BOX_R);
    if (sl) exp_l_n = 1'b0; else if (cl) exp_l_n = 1'b1;
    if (sr) exp_r_n = 1'b0; else if (cr) exp_r_n = 1'b1;
    q_exp.push_back({exp_l_n, exp_r_n});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, 1, '0, 0, 0, 0, 1, '0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) check(q_tag.pop_front(), {lft_irq_n, rgt_irq_n}, q_exp.pop_front());
    end
  end

  initial begin
    #(CLK_P * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", {lft_irq_n, rgt_irq_n}, 2'b11);
    rst_n = 1'b1;
    idle("R1 after release");
    idle("R10 idle hold");
    cyc("R2 right writes 0x7FFE", 0, 0, 0, 1, '0, 1, 1, 0, 1, BOX_L);
    idle("R10 hold low");
    cyc("R7 left read without oe", 1, 0, 0, 1, BOX_L, 0, 0, 0, 1, '0);
    cyc("R7 oe without strobe", 0, 0, 1, 1, BOX_L, 0, 0, 0, 1, '0);
    cyc("R4 clear with wr=1", 1, 1, 1, 1, BOX_L, 0, 0, 0, 1, '0);
    cyc("R3 left writes 0x7FFF", 1, 1, 0, 1, BOX_R, 0, 0, 0, 1, '0);
    cyc("R9 right reads other mailbox", 0, 0, 0, 1, '0, 1, 0, 1, 1, BOX_L);
    cyc("R5 right reads 0x7FFF", 0, 0, 0, 1, '0, 1, 0, 1, 1, BOX_R);
    cyc("R6 both writes inhibited", 1, 1, 0, 0, BOX_R, 1, 1, 0, 0, BOX_L);
    idle("R6 still clear");
    cyc("R8 set and clear left", 1, 0, 1, 1, BOX_L, 1, 1, 0, 1, BOX_L);
    cyc("R4 left reads 0x7FFE", 1, 0, 1, 1, BOX_L, 0, 0, 0, 1, '0);
    cyc("R9 other addresses", 1, 1, 0, 1, 15'h0000, 1, 1, 0, 1, 15'h7FFD);
    cyc("R9 own mailbox writes", 1, 1, 0, 1, BOX_L, 1, 1, 0, 1, BOX_R);
    cyc("R3 set right again", 1, 1, 0, 1, BOX_R, 0, 0, 0, 1, '0);
    cyc("R8 set and clear right", 1, 1, 0, 1, BOX_R, 1, 0, 1, 1, BOX_R);
    cyc("R5 clear with wr=1", 0, 0, 0, 1, '0, 1, 1, 1, 1, BOX_R);
    cyc("R2 R3 both set", 1, 1, 0, 1, BOX_R, 1, 1, 0, 1, BOX_L);
    idle("R10 both held");
    cyc("R4 R5 both cleared", 1, 0, 1, 1, BOX_L, 1, 0, 1, 1, BOX_R);
    cyc("R2 R3 set before reset", 1, 1, 0, 1, BOX_R, 1, 1, 0, 1, BOX_L);
    idle("R10 hold before reset");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", {lft_irq_n, rgt_irq_n}, 2'b11);
    exp_l_n = 1'b1;
    exp_r_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 after second release");
    idle("R10 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule